// File: doc/BRIEF.md
# Tone Wake-Up Duty-Cycle Controller

This block lets a sleeping sensor node listen for a long wake-up tone while its receiver stays off almost all the time. When enabled, it switches the receiver on for a short check window, long enough only for the radio to come up, and watches a carrier/energy detect line. If the line stays quiet for the whole window, the receiver is switched off and the node sleeps for a long interval before the next check. In idle this gives a receiver duty cycle of about 0.005 percent. The sender's tone must last longer than one sleep interval plus one check window, so that it cannot fall entirely inside a sleep.

If energy appears during a check, the receiver stays on and the block confirms the tone. The detect line must stay high for a set number of consecutive cycles. A dropout restarts the count, and a confirmation phase that runs too long drops back to sleep. A confirmed tone raises a wake request to the host, which holds until the host acknowledges it. After that the receiver stays on, idle, until the enable is dropped and raised again. The detect line is treated as asynchronous and passes through a two-flop synchronizer. The check window, sleep interval, confirmation length and confirmation timeout are parameters in clock cycles. Their defaults suit a 200 MHz clock: 200 us check, 4 s sleep.

Top module: `tone_wake_ctrl`

## Requirements
- R1: While reset is asserted, and whenever `enable` is low, `status` is 0 (off), `radio_on` is 0 and `wake_req` is 0; `energy_det` has no effect in this state.
- R2: On the first clock edge at which the block is off and `enable` is high, it enters the check state (`status` = 2) with `radio_on` = 1.
- R3: A check in which no synchronized energy is seen lasts CHECK_CYC cycles, then the block enters sleep (`status` = 1, `radio_on` = 0) for SLEEP_CYC cycles, then starts a new check.
- R4: `energy_det` is used only after two synchronizer flops, so a level driven before clock edge k takes effect on the control state at edge k+2; energy during sleep does not change the state or the sleep length.
- R5: Synchronized energy seen in a check moves the block to confirmation (`status` = 3, `radio_on` = 1) on the next edge, counting that sample as the first of the run.
- R6: Confirmation succeeds when synchronized energy has been high for CONF_LEN consecutive cycles (CONF_LEN at least 2); a single low sample clears the run to zero.
- R7: If confirmation has not succeeded after CONF_TMO cycles in the confirmation state, the block returns to sleep.
- R8: When the run completes on the same edge at which the confirmation timeout expires, the confirmation wins and the block wakes.
- R9: On success, `status` = 4 and `wake_req` = 1 with `radio_on` = 1, held until `wake_ack` is high at an edge. The block then goes to hold (`status` = 5, `radio_on` = 1, `wake_req` = 0) and stays there while `enable` is high.
- R10: `enable` low at an edge sends the block to off (`status` = 0) from any state, with priority over every other transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the duty-cycled listening; low forces off |
| energy_det | input | 1 | Asynchronous carrier/energy detect from the receiver |
| wake_ack | input | 1 | Host acknowledge of the wake request |
| radio_on | output | 1 | Receiver power control |
| wake_req | output | 1 | Wake request to the host |
| status | output | 3 | State code: 0 off, 1 sleep, 2 check, 3 confirm, 4 wake, 5 hold |

## Verification
The run counter completing a confirmation and the timeout counter expiring can both fall on one edge. The bench holds the detect line high from before the first check, then drives a dropout pattern that clears the run three times. This makes the fourth consecutive high sample land exactly on the edge where the confirmation counter reaches its last value. The outcome is read from `status` one edge later: wake (4) is correct, while sleep (1) means the timeout took priority.

// File: rtl/twk_pkg.sv
package twk_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_SLEEP   = 3'd1,
        ST_CHECK   = 3'd2,
        ST_CONFIRM = 3'd3,
        ST_WAKE    = 3'd4,
        ST_HOLD    = 3'd5
    } twk_state_e;

endpackage

// File: rtl/twk_sync.sv
module twk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/twk_seq.sv
module twk_seq
    import twk_pkg::*;
#(
    parameter int CHECK_CYC = 40_000,
    parameter int SLEEP_CYC = 800_000_000,
    parameter int CONF_LEN  = 2_000,
    parameter int CONF_TMO  = 200_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       det_s,
    input  logic       wake_ack,
    output twk_state_e state_o
);

    localparam int MAX_A  = (SLEEP_CYC > CHECK_CYC) ? SLEEP_CYC : CHECK_CYC;
    localparam int MAX_C  = (MAX_A > CONF_TMO) ? MAX_A : CONF_TMO;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int RUN_W  = $clog2(CONF_LEN);
    localparam logic [CNT_W-1:0] CHECK_LAST = CNT_W'(CHECK_CYC - 1);
    localparam logic [CNT_W-1:0] SLEEP_LAST = CNT_W'(SLEEP_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(CONF_TMO - 1);
    localparam logic [RUN_W-1:0] RUN_LAST   = RUN_W'(CONF_LEN - 1);

    typedef struct packed {
        twk_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [RUN_W-1:0] run;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_OFF: begin
                if (enable) begin
                    seq_d.st  = ST_CHECK;
                    seq_d.cnt = '0;
                    seq_d.run = '0;
                end
            end
            ST_SLEEP: begin
                if (seq_q.cnt == SLEEP_LAST) begin
                    seq_d.st  = ST_CHECK;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_CHECK: begin
                if (det_s) begin
                    seq_d.st  = ST_CONFIRM;
                    seq_d.cnt = '0;
                    seq_d.run = RUN_W'(1);
                end else if (seq_q.cnt == CHECK_LAST) begin
                    seq_d.st  = ST_SLEEP;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_CONFIRM: begin
                if (det_s && seq_q.run == RUN_LAST) begin
                    seq_d.st  = ST_WAKE;
                    seq_d.cnt = '0;
                    seq_d.run = '0;
                end else begin
                    seq_d.run = det_s ? seq_q.run + 1'b1 : '0;
                    if (seq_q.cnt == TMO_LAST) begin
                        seq_d.st  = ST_SLEEP;
                        seq_d.cnt = '0;
                        seq_d.run = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_WAKE: begin
                if (wake_ack) seq_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                seq_d.st = ST_HOLD;
            end
            default: begin
                seq_d.st = ST_OFF;
            end
        endcase
        if (!enable) begin
            seq_d.st  = ST_OFF;
            seq_d.cnt = '0;
            seq_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_OFF, cnt: '0, run: '0};
        else        seq_q <= seq_d;
    end

    assign state_o = seq_q.st;

    // R2: enable while off starts a check on the next edge
    a_r2_start_check: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_OFF && enable) |=> (seq_q.st == ST_CHECK));

    // R10: enable low forces off from any state
    a_r10_force_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (seq_q.st == ST_OFF));

    // R3: a quiet check ends in sleep when its window is used up
    a_r3_quiet_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_CHECK && seq_q.cnt == CHECK_LAST && !det_s && enable)
        |=> (seq_q.st == ST_SLEEP));

    // R6: waking is only reached from confirmation with energy present
    a_r6_wake_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAKE && $past(seq_q.st) != ST_WAKE)
        |-> ($past(seq_q.st) == ST_CONFIRM && $past(det_s)));

    // R7: confirmation never outlasts its timeout window
    a_r7_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_CONFIRM) |-> (seq_q.cnt <= TMO_LAST));

    // R4: sleep ignores energy and keeps counting
    a_r4_sleep_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_SLEEP && seq_q.cnt != SLEEP_LAST && enable)
        |=> (seq_q.st == ST_SLEEP));

endmodule

// File: rtl/tone_wake_ctrl.sv
module tone_wake_ctrl
    import twk_pkg::*;
#(
    parameter int CHECK_CYC = 40_000,
    parameter int SLEEP_CYC = 800_000_000,
    parameter int CONF_LEN  = 2_000,
    parameter int CONF_TMO  = 200_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       energy_det,
    input  logic       wake_ack,
    output logic       radio_on,
    output logic       wake_req,
    output logic [2:0] status
);

    logic       det_s;
    twk_state_e st;

    twk_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (energy_det),
        .sync_out (det_s)
    );

    twk_seq #(
        .CHECK_CYC (CHECK_CYC),
        .SLEEP_CYC (SLEEP_CYC),
        .CONF_LEN  (CONF_LEN),
        .CONF_TMO  (CONF_TMO)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .det_s    (det_s),
        .wake_ack (wake_ack),
        .state_o  (st)
    );

    always_comb begin
        radio_on = (st == ST_CHECK) || (st == ST_CONFIRM) ||
                   (st == ST_WAKE)  || (st == ST_HOLD);
        wake_req = (st == ST_WAKE);
        status   = st;
    end

    // R9: the wake request holds until acknowledged
    a_r9_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_ack && enable) |=> wake_req);

    // R9: the receiver stays powered while a wake is requested
    a_r9_wake_radio: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> radio_on);

    // R1: the receiver is off after an edge with enable low
    a_r1_off_radio: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !radio_on && !wake_req);

endmodule

// File: tb/sim_tone_wake_ctrl.sv
`timescale 1ns/1ps
module sim_tone_wake_ctrl;

    localparam int CHECK_CYC = 6;
    localparam int SLEEP_CYC = 10;
    localparam int CONF_LEN  = 4;
    localparam int CONF_TMO  = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable, energy_det, wake_ack;
    logic       radio_on, wake_req;
    logic [2:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tone_wake_ctrl #(
        .CHECK_CYC (CHECK_CYC),
        .SLEEP_CYC (SLEEP_CYC),
        .CONF_LEN  (CONF_LEN),
        .CONF_TMO  (CONF_TMO)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .energy_det (energy_det),
        .wake_ack   (wake_ack),
        .radio_on   (radio_on),
        .wake_req   (wake_req),
        .status     (status)
    );

    // {enable, detect, ack, edges[4:0], expected status[2:0], requirement[3:0]}
    localparam int NV = 20;
    localparam logic [14:0] VEC [NV] = '{
        {3'b000, 5'd3,  3'd0, 4'd1},   // R1 enable low stays off
        {3'b100, 5'd2,  3'd2, 4'd2},   // R2 check starts
        {3'b100, 5'd6,  3'd1, 4'd3},   // R3 quiet check ends in sleep
        {3'b100, 5'd5,  3'd1, 4'd3},   // R3 sleep continues
        {3'b110, 5'd2,  3'd1, 4'd4},   // R4 energy during sleep ignored
        {3'b110, 5'd2,  3'd2, 4'd3},   // R3 sleep length then new check
        {3'b110, 5'd1,  3'd3, 4'd5},   // R5 energy in check -> confirm
        {3'b100, 5'd1,  3'd3, 4'd6},   // R6 one-cycle dropout driven
        {3'b110, 5'd5,  3'd3, 4'd6},   // R6 dropout restarted the run
        {3'b110, 5'd1,  3'd4, 4'd6},   // R6 full run -> wake
        {3'b110, 5'd3,  3'd4, 4'd9},   // R9 wake held without ack
        {3'b111, 5'd1,  3'd5, 4'd9},   // R9 ack -> hold
        {3'b100, 5'd5,  3'd5, 4'd9},   // R9 hold persists
        {3'b000, 5'd1,  3'd0, 4'd10},  // R10 enable low from hold
        {3'b110, 5'd1,  3'd2, 4'd2},   // R2 restart
        {3'b100, 5'd1,  3'd2, 4'd4},   // R4 two-flop latency
        {3'b100, 5'd12, 3'd3, 4'd7},   // R7 still confirming
        {3'b100, 5'd1,  3'd1, 4'd7},   // R7 timeout -> sleep
        {3'b000, 5'd1,  3'd0, 4'd10},  // R10 off from sleep
        {3'b100, 5'd3,  3'd2, 4'd2}    // R2 check again
    };

    task automatic check_out(input logic [2:0] exp_st, input int req, input string tag);
        logic exp_radio, exp_wake;
        exp_radio = (exp_st >= 3'd2);
        exp_wake  = (exp_st == 3'd4);
        n_chk++;
        if (status !== exp_st || radio_on !== exp_radio || wake_req !== exp_wake) begin
            n_fail++;
            $display("FAIL R%0d %s: status=%0d radio=%b wake=%b, expected status=%0d radio=%b wake=%b",
                     req, tag, status, radio_on, wake_req, exp_st, exp_radio, exp_wake);
        end
    endtask

    // R8 pattern: detect levels driven before edges 1..12 of the priority test
    localparam logic [12:1] PRIO_PAT = 12'b1111_0110_1101;

    initial begin
        rst_n = 1'b0; enable = 1'b0; energy_det = 1'b0; wake_ack = 1'b0;
        repeat (3) @(negedge clk);
        check_out(3'd0, 1, "reset state");            // R1
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {enable, energy_det, wake_ack} = VEC[i][14:12];
            repeat (int'(VEC[i][11:7])) @(posedge clk);
            @(negedge clk);
            check_out(VEC[i][6:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
        end

        // R8: run completion and timeout on the same edge
        rst_n = 1'b0; enable = 1'b0; energy_det = 1'b1; wake_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_out(3'd0, 1, "off with energy present");   // R1
        for (int i = 1; i <= 14; i++) begin
            enable     = 1'b1;
            energy_det = (i <= 12) ? PRIO_PAT[i] : 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (i == 1)  check_out(3'd2, 2, "priority test check");       // R2
            if (i == 2)  check_out(3'd3, 5, "priority test confirm");     // R5
            if (i == 13) check_out(3'd3, 8, "before coincident edge");    // R8
            if (i == 14) check_out(3'd4, 8, "confirm beats timeout");     // R8
        end

        // R9 / R10: wake without ack held, then enable drop from wake
        energy_det = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_out(3'd4, 9, "wake held");              // R9
        enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_out(3'd0, 10, "off from wake");         // R10

        // R1: reset in the middle of a check
        enable = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_out(3'd0, 1, "asynchronous reset");     // R1
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule